// File: doc/BRIEF.md
# Source-Routed Parcel Switching Node

This block is one functional-unit node in a mesh of units that hand work parcels to one another. Every parcel carries a thread tag, a payload of several link beats and its own hop list. Each hop names a destination port and a service code. Several upstream links compete for the node. A round-robin arbiter grants one of them, and the granted link then owns the node until all beats of its parcel have been taken. While the beats come in, the node applies a small stub service, chosen by the leading hop, to each payload beat.

Once the last beat has arrived, the node removes the hop it has just served. It then stores the finished parcel in a small output queue. The parcel leaves through the port named by the hop that is now at the front of the list. Two cases redirect a parcel to the fetch port. A fault found by the check service replaces the rest of the hop list with a single program-check hop. A parcel whose hop list is used up goes to the fetch port with an empty list, so that its thread can issue its next instruction.

All links use valid/ready handshaking. The output side is one shared data bus with a separate valid bit and ready bit for each destination port.

Top module: `psn_node`

## Requirements
- R1: The hop list is a 3-bit remaining-hop count in bits [2:0], followed by hop k at bits [3+5k +: 5]. Within a hop, the service code sits in the low 3 bits and the port in the upper 2 bits. Hop 0 is the leading hop. The node consumes hop 0: the outgoing list holds the remaining hops moved down one place, the count is lowered by one, and the parcel leaves on the port of the new hop 0.
- R2: At most one input link transfers a beat in any clock cycle, even when several links present valid together.
- R3: Arbitration between parcels is round-robin. After a parcel from link i completes, the search for the next grant starts at link i+1 and wraps around. Links that lose keep their valid and data and are served later.
- R4: The output queue holds 2 parcels. While it is full, every in_ready is low, and no parcel is lost.
- R5: Service code 3 (check) faults when any payload beat has its top bit set. A faulting parcel goes to port 0 with count 1 and hop 0 = {port 0, code 7}, and its payload is unchanged. Without a fault, code 3 behaves like a normal hop.
- R6: A parcel is 2 beats. All beats of one parcel are taken from a single link with no other link's beats between them. The output sends beat 0 then beat 1, with out_last high only on beat 1.
- R7: When the count after stripping is 0, or the incoming count is 0, the parcel goes to port 0 with an all-zero hop list.
- R8: The thread tag leaves the node exactly as it arrived.
- R9: Service codes on each payload beat: 0 passes the beat through, 1 adds one modulo 2^16, 2 inverts every bit, and 3 passes the beat through. The codes not listed pass the beat through.
- R10: A beat moves only when valid and ready are both high. While an output beat is stalled, out_valid, out_data, out_route and out_tid stay stable.
- R11: During reset and directly after it, out_valid is all zero and no input beat is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_IN | Beat offered on each input link |
| in_ready | output | NUM_IN | Beat taken on each input link |
| in_data | input | NUM_IN*BEAT_W | Payload beat for each link |
| in_route | input | NUM_IN*ROUTE_W | Hop list for each link, held for the whole parcel |
| in_tid | input | NUM_IN*TID_W | Thread tag for each link, held for the whole parcel |
| out_valid | output | NUM_OUT | Beat offered to each destination port |
| out_ready | input | NUM_OUT | Destination ready for each port |
| out_data | output | BEAT_W | Shared outgoing payload beat |
| out_route | output | ROUTE_W | Outgoing hop list |
| out_tid | output | TID_W | Outgoing thread tag |
| out_last | output | 1 | Final beat of the parcel |

## Verification
The main path is driven by parcels whose leading hop selects each service code, including an increment that wraps past all ones. Two check-service parcels differ only in whether a beat has its top bit set, which separates the fault rewrite from normal forwarding. A three-hop and a one-hop list separate the ordinary strip-and-forward case from an exhausted route. Competing parcels sent while the outputs are stalled show round-robin order against fixed priority, show that a full queue holds every link back, and show that beats stay in order and are not interleaved while ready toggles.

// File: rtl/psn_pkg.sv
package psn_pkg;
   localparam int CTL_W = 3;

   typedef enum logic [CTL_W-1:0] {
      SVC_PASS   = 3'd0,
      SVC_INC    = 3'd1,
      SVC_INV    = 3'd2,
      SVC_CHECK  = 3'd3,
      SVC_PGMCHK = 3'd7
   } svc_e;
endpackage

// File: rtl/psn_rr_arb.sv
module psn_rr_arb #(
   parameter int N = 3,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   input  logic [IDX_W-1:0] ptr,
   output logic [IDX_W-1:0] gnt_idx,
   output logic             gnt_vld
);
   always_comb begin
      gnt_idx = '0;
      gnt_vld = |req;
      // walk offsets from far to near so the nearest requester wins
      for (int i = N - 1; i >= 0; i--) begin
         if (req[(int'(ptr) + i) % N]) gnt_idx = IDX_W'((int'(ptr) + i) % N);
      end
   end
endmodule

// File: rtl/psn_svc.sv
module psn_svc
   import psn_pkg::*;
#(
   parameter int BEAT_W = 16
) (
   input  logic [CTL_W-1:0]  ctl,
   input  logic [BEAT_W-1:0] din,
   output logic [BEAT_W-1:0] dout,
   output logic              fault
);
   always_comb begin
      dout  = din;
      fault = 1'b0;
      if (ctl == SVC_INC)        dout  = din + BEAT_W'(1);
      else if (ctl == SVC_INV)   dout  = ~din;
      else if (ctl == SVC_CHECK) fault = din[BEAT_W-1];
   end
endmodule

// File: rtl/psn_route.sv
module psn_route
   import psn_pkg::*;
#(
   parameter int PORT_W     = 2,
   parameter int MAX_HOPS   = 4,
   parameter int CNT_W      = 3,
   parameter int FETCH_PORT = 0,
   localparam int ENT_W     = PORT_W + CTL_W,
   localparam int LIST_W    = MAX_HOPS * ENT_W,
   localparam int ROUTE_W   = CNT_W + LIST_W
) (
   input  logic [ROUTE_W-1:0] route_in,
   input  logic               fault,
   output logic [PORT_W-1:0]  dest,
   output logic [ROUTE_W-1:0] route_out
);
   logic [CNT_W-1:0]  cnt_in;
   logic [LIST_W-1:0] hops_in, hops_shift;

   assign cnt_in     = route_in[CNT_W-1:0];
   assign hops_in    = route_in[ROUTE_W-1:CNT_W];
   assign hops_shift = hops_in >> ENT_W;

   always_comb begin
      if (fault) begin
         dest      = PORT_W'(FETCH_PORT);
         route_out = {LIST_W'({PORT_W'(FETCH_PORT), SVC_PGMCHK}), CNT_W'(1)};
      end else if (cnt_in <= CNT_W'(1)) begin
         dest      = PORT_W'(FETCH_PORT);
         route_out = '0;
      end else begin
         dest      = hops_shift[CTL_W +: PORT_W];
         route_out = {hops_shift, cnt_in - CNT_W'(1)};
      end
   end
endmodule

// File: rtl/psn_fifo.sv
module psn_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 2,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic         full,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   count;

   assign full    = (count == (AW+1)'(DEPTH));
   assign empty   = (count == '0);
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + AW'(1);
         if (rd_en) rd_ptr <= rd_ptr + AW'(1);
         count <= count + (AW+1)'(wr_en) - (AW+1)'(rd_en);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full); // R4
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty); // R4
endmodule

// File: rtl/psn_node.sv
module psn_node
   import psn_pkg::*;
#(
   parameter int NUM_IN     = 3,
   parameter int NUM_OUT    = 4,
   parameter int BEAT_W     = 16,
   parameter int BEATS      = 2,
   parameter int TID_W      = 4,
   parameter int MAX_HOPS   = 4,
   parameter int OBUF_DEPTH = 2,
   parameter int FETCH_PORT = 0,
   localparam int PORT_W    = $clog2(NUM_OUT),
   localparam int CNT_W     = $clog2(MAX_HOPS + 1),
   localparam int ENT_W     = PORT_W + CTL_W,
   localparam int ROUTE_W   = CNT_W + MAX_HOPS * ENT_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_IN-1:0]          in_valid,
   output logic [NUM_IN-1:0]          in_ready,
   input  logic [NUM_IN*BEAT_W-1:0]   in_data,
   input  logic [NUM_IN*ROUTE_W-1:0]  in_route,
   input  logic [NUM_IN*TID_W-1:0]    in_tid,
   output logic [NUM_OUT-1:0]         out_valid,
   input  logic [NUM_OUT-1:0]         out_ready,
   output logic [BEAT_W-1:0]          out_data,
   output logic [ROUTE_W-1:0]         out_route,
   output logic [TID_W-1:0]           out_tid,
   output logic                       out_last
);
   localparam int IN_W    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
   localparam int BC_W    = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int PAY_W   = BEATS * BEAT_W;
   localparam int ENTRY_W = PORT_W + TID_W + ROUTE_W + PAY_W;

   // elaboration-time parameter checks
   if (NUM_OUT < 2)                   begin : g_chk_out  $error("psn_node: NUM_OUT below 2"); end
   if (NUM_IN < 1)                    begin : g_chk_in   $error("psn_node: NUM_IN below 1"); end
   if (FETCH_PORT >= NUM_OUT)         begin : g_chk_ftch $error("psn_node: FETCH_PORT out of range"); end
   if (BEATS < 1)                     begin : g_chk_bts  $error("psn_node: BEATS below 1"); end
   if (MAX_HOPS < 1)                  begin : g_chk_hops $error("psn_node: MAX_HOPS below 1"); end
   if (OBUF_DEPTH < 2 || (OBUF_DEPTH & (OBUF_DEPTH - 1)) != 0)
                                      begin : g_chk_dep  $error("psn_node: OBUF_DEPTH not a power of two >= 2"); end

   // ---------------- input side: arbitration and parcel assembly ----------------
   logic [BC_W-1:0]    in_beat_q;
   logic [IN_W-1:0]    lock_q, rr_q, arb_idx, gnt_idx;
   logic               arb_vld, gnt_vld, locked, take, last_beat;
   logic [ROUTE_W-1:0] hdr_route_q, cur_route, new_route;
   logic [TID_W-1:0]   hdr_tid_q, cur_tid;
   logic [PAY_W-1:0]   pay_q, pay_next;
   logic               fault_q, fault_all, svc_fault;
   logic [BEAT_W-1:0]  cur_data, svc_data;
   logic [CTL_W-1:0]   svc_ctl;
   logic [PORT_W-1:0]  new_dest;
   logic               fifo_full, fifo_empty, pop;
   logic [ENTRY_W-1:0] fifo_rd;

   psn_rr_arb #(.N(NUM_IN)) u_arb (
      .req(in_valid), .ptr(rr_q), .gnt_idx(arb_idx), .gnt_vld(arb_vld));

   assign locked    = (in_beat_q != '0);
   assign gnt_idx   = locked ? lock_q : arb_idx;
   assign gnt_vld   = locked | arb_vld;
   assign take      = gnt_vld && !fifo_full && in_valid[gnt_idx];
   assign last_beat = (in_beat_q == BC_W'(BEATS - 1));
   assign cur_data  = in_data[gnt_idx*BEAT_W +: BEAT_W];
   assign cur_route = locked ? hdr_route_q : in_route[gnt_idx*ROUTE_W +: ROUTE_W];
   assign cur_tid   = locked ? hdr_tid_q   : in_tid[gnt_idx*TID_W +: TID_W];
   assign svc_ctl   = (cur_route[CNT_W-1:0] == '0) ? SVC_PASS : cur_route[CNT_W +: CTL_W];
   assign fault_all = fault_q | svc_fault;

   always_comb begin
      in_ready = '0;
      if (gnt_vld && !fifo_full) in_ready[gnt_idx] = 1'b1;
   end

   psn_svc #(.BEAT_W(BEAT_W)) u_svc (
      .ctl(svc_ctl), .din(cur_data), .dout(svc_data), .fault(svc_fault));

   psn_route #(.PORT_W(PORT_W), .MAX_HOPS(MAX_HOPS), .CNT_W(CNT_W), .FETCH_PORT(FETCH_PORT)) u_route (
      .route_in(cur_route), .fault(fault_all), .dest(new_dest), .route_out(new_route));

   always_comb begin
      pay_next = pay_q;
      pay_next[in_beat_q*BEAT_W +: BEAT_W] = svc_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_beat_q   <= '0;
         lock_q      <= '0;
         rr_q        <= '0;
         fault_q     <= 1'b0;
         hdr_route_q <= '0;
         hdr_tid_q   <= '0;
         pay_q       <= '0;
      end else if (take) begin
         hdr_route_q <= cur_route;
         hdr_tid_q   <= cur_tid;
         lock_q      <= gnt_idx;
         pay_q       <= pay_next;
         if (last_beat) begin
            in_beat_q <= '0;
            fault_q   <= 1'b0;
            rr_q      <= IN_W'((int'(gnt_idx) + 1) % NUM_IN);
         end else begin
            in_beat_q <= in_beat_q + BC_W'(1);
            fault_q   <= fault_all;
         end
      end
   end

   psn_fifo #(.W(ENTRY_W), .DEPTH(OBUF_DEPTH)) u_obuf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(take && last_beat), .wr_data({new_dest, cur_tid, new_route, pay_next}),
      .full(fifo_full), .rd_en(pop), .rd_data(fifo_rd), .empty(fifo_empty));

   // ---------------- output side: beat serialiser ----------------
   logic [BC_W-1:0]   out_beat_q;
   logic [PORT_W-1:0] head_dest;
   logic [PAY_W-1:0]  head_pay;
   logic              xfer;

   assign head_dest = fifo_rd[ENTRY_W-1 -: PORT_W];
   assign out_tid   = fifo_rd[PAY_W + ROUTE_W +: TID_W];
   assign out_route = fifo_rd[PAY_W +: ROUTE_W];
   assign head_pay  = fifo_rd[PAY_W-1:0];
   assign out_valid = fifo_empty ? '0 : (NUM_OUT'(1) << head_dest);
   assign out_last  = (out_beat_q == BC_W'(BEATS - 1));
   assign xfer      = |(out_valid & out_ready);
   assign pop       = xfer && out_last;

   if (BEATS == 1) begin : g_one_beat
      assign out_data = head_pay;
   end else begin : g_multi_beat
      assign out_data = head_pay[out_beat_q*BEAT_W +: BEAT_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    out_beat_q <= '0;
      else if (pop)  out_beat_q <= '0;
      else if (xfer) out_beat_q <= out_beat_q + BC_W'(1);
   end

   AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_valid & in_ready)); // R2
   AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (((in_valid & in_ready) & ~(NUM_IN'(1) << lock_q)) == '0)); // R6
   AST_PARCEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> in_valid[lock_q]); // R3
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((|out_valid) && !(|(out_valid & out_ready))) |=>
         (out_valid == $past(out_valid)) && $stable(out_data) && $stable(out_route) && $stable(out_tid)); // R10
endmodule

// File: tb/psn_node_tb_top.sv
module psn_node_tb_top;
   localparam int NI = 3, NO = 4, BW = 16, TW = 4, RW = 23;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [NI-1:0]    in_valid, in_ready;
   logic [NI*BW-1:0] in_data;
   logic [NI*RW-1:0] in_route;
   logic [NI*TW-1:0] in_tid;
   logic [NO-1:0]    out_valid, out_ready;
   logic [BW-1:0]    out_data;
   logic [RW-1:0]    out_route;
   logic [TW-1:0]    out_tid;
   logic             out_last;

   logic          drv_valid [NI];
   logic [BW-1:0] drv_data  [NI];
   logic [RW-1:0] drv_route [NI];
   logic [TW-1:0] drv_tid   [NI];

   always_comb begin
      for (int p = 0; p < NI; p++) begin
         in_valid[p] = drv_valid[p];
         in_data[p*BW +: BW] = drv_data[p];
         in_route[p*RW +: RW] = drv_route[p];
         in_tid[p*TW +: TW] = drv_tid[p];
      end
   end

   psn_node dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_route(in_route), .in_tid(in_tid),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_route(out_route), .out_tid(out_tid), .out_last(out_last));

   int checks = 0, errors = 0;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [RW-1:0] mk_route(input int cnt, input int p0, input int c0,
      input int p1, input int c1, input int p2, input int c2);
      logic [RW-1:0] r;
      r = '0;
      r[2:0]  = 3'(cnt);
      r[3 +: 5]  = {2'(p0), 3'(c0)};
      r[8 +: 5]  = {2'(p1), 3'(c1)};
      r[13 +: 5] = {2'(p2), 3'(c2)};
      return r;
   endfunction

   // ready control: 0 all ready, 1 none ready, 2 toggling
   int rdy_mode = 0;
   always @(posedge clk) begin
      case (rdy_mode)
         0: out_ready <= '1;
         1: out_ready <= '0;
         default: out_ready <= out_ready[0] ? '0 : '1;
      endcase
   end

   // output monitor, samples at the falling edge
   int            rx_count = 0, mon_beat = 0;
   logic [1:0]    rx_dest  [16];
   logic [RW-1:0] rx_route [16];
   logic [TW-1:0] rx_tid   [16];
   logic [BW-1:0] rx_b0 [16], rx_b1 [16];
   logic          hold_pend = 1'b0;
   logic [NO-1:0] prev_valid;
   logic [BW-1:0] prev_data;
   logic [RW-1:0] prev_route;

   always @(negedge clk) begin
      if (rst_n) begin
         if (|in_valid) chk(32'($countones(in_valid & in_ready) <= 1), 1, "R2 one beat per cycle");
         if (hold_pend) begin
            chk({out_valid, out_data}, {prev_valid, prev_data}, "R10 stalled beat stable");
            chk(out_route, prev_route, "R10 stalled route stable");
         end
         hold_pend  = (|out_valid) && !(|(out_valid & out_ready));
         prev_valid = out_valid;
         prev_data  = out_data;
         prev_route = out_route;
         if (|(out_valid & out_ready)) begin
            chk(out_last, (mon_beat == 1), "R6 out_last position");
            if (mon_beat == 0) begin
               for (int d = 0; d < NO; d++) if (out_valid[d]) rx_dest[rx_count % 16] = 2'(d);
               rx_route[rx_count % 16] = out_route;
               rx_tid[rx_count % 16]   = out_tid;
               rx_b0[rx_count % 16]    = out_data;
               mon_beat = 1;
            end else begin
               rx_b1[rx_count % 16] = out_data;
               mon_beat = 0;
               rx_count++;
            end
         end
      end
   end

   task automatic send(input int p, input logic [RW-1:0] r, input logic [TW-1:0] t,
                       input logic [BW-1:0] b0, input logic [BW-1:0] b1);
      for (int b = 0; b < 2; b++) begin
         bit acc = 1'b0;
         while (!acc) begin
            @(negedge clk);
            drv_valid[p] = 1'b1;
            drv_data[p]  = (b == 0) ? b0 : b1;
            drv_route[p] = r;
            drv_tid[p]   = t;
            #1;
            acc = in_ready[p];
         end
      end
      @(negedge clk);
      drv_valid[p] = 1'b0;
   endtask

   task automatic wait_rx(input int n, input string tag);
      int t = 0;
      while (rx_count < n && t < 400) begin
         @(negedge clk);
         t++;
      end
      chk(32'(rx_count >= n), 1, tag);
   endtask

   typedef struct packed {
      logic [1:0] src; logic [2:0] cnt;
      logic [1:0] p0; logic [2:0] c0; logic [1:0] p1; logic [2:0] c1; logic [1:0] p2; logic [2:0] c2;
      logic [3:0] tid; logic [15:0] b0; logic [15:0] b1;
      logic [1:0] edst; logic [2:0] ecnt; logic [1:0] ep0; logic [2:0] ec0; logic [1:0] ep1; logic [2:0] ec1;
      logic [15:0] eb0; logic [15:0] eb1;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{2'd0, 3'd3, 2'd1, 3'd0, 2'd2, 3'd1, 2'd3, 3'd2, 4'h5, 16'h1234, 16'h00FF,
        2'd2, 3'd2, 2'd2, 3'd1, 2'd3, 3'd2, 16'h1234, 16'h00FF},
      '{2'd1, 3'd2, 2'd1, 3'd1, 2'd3, 3'd0, 2'd0, 3'd0, 4'h9, 16'hFFFF, 16'h0010,
        2'd3, 3'd1, 2'd3, 3'd0, 2'd0, 3'd0, 16'h0000, 16'h0011},
      '{2'd2, 3'd2, 2'd1, 3'd2, 2'd1, 3'd4, 2'd0, 3'd0, 4'hF, 16'h0F0F, 16'hA5A5,
        2'd1, 3'd1, 2'd1, 3'd4, 2'd0, 3'd0, 16'hF0F0, 16'h5A5A},
      '{2'd0, 3'd1, 2'd1, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 4'h3, 16'hAAAA, 16'h5555,
        2'd0, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 16'hAAAA, 16'h5555},
      '{2'd1, 3'd2, 2'd1, 3'd3, 2'd2, 3'd0, 2'd0, 3'd0, 4'h6, 16'h7000, 16'h8001,
        2'd0, 3'd1, 2'd0, 3'd7, 2'd0, 3'd0, 16'h7000, 16'h8001},
      '{2'd2, 3'd2, 2'd1, 3'd3, 2'd2, 3'd5, 2'd0, 3'd0, 4'hA, 16'h7FFF, 16'h0001,
        2'd2, 3'd1, 2'd2, 3'd5, 2'd0, 3'd0, 16'h7FFF, 16'h0001}
   };

   // watchdog
   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [RW-1:0] rt;
      int base;
      for (int p = 0; p < NI; p++) begin
         drv_valid[p] = 1'b0; drv_data[p] = '0; drv_route[p] = '0; drv_tid[p] = '0;
      end
      repeat (3) @(negedge clk);
      chk(out_valid, 0, "R11 out_valid in reset");
      chk(in_ready, 0, "R11 in_ready in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid, 0, "R11 out_valid after reset");

      // table walk: R1 strip, R5 fault, R7 exhausted route, R8 tag, R9 services
      for (int v = 0; v < 6; v++) begin
         string tg;
         case (v)
            0: tg = "R1"; 1: tg = "R9 inc"; 2: tg = "R9 inv";
            3: tg = "R7"; 4: tg = "R5 fault"; default: tg = "R5 no-fault";
         endcase
         send(int'(VECS[v].src), mk_route(VECS[v].cnt, VECS[v].p0, VECS[v].c0, VECS[v].p1,
              VECS[v].c1, VECS[v].p2, VECS[v].c2), VECS[v].tid, VECS[v].b0, VECS[v].b1);
         wait_rx(v + 1, {tg, " delivered"});
         rt = mk_route(VECS[v].ecnt, VECS[v].ep0, VECS[v].ec0, VECS[v].ep1, VECS[v].ec1, 0, 0);
         chk(rx_dest[v], VECS[v].edst, {tg, " dest"});
         chk(rx_route[v], rt, {tg, " route"});
         chk(rx_tid[v], VECS[v].tid, "R8 tag");
         chk({rx_b0[v], rx_b1[v]}, {VECS[v].eb0, VECS[v].eb1}, {tg, " payload"});
      end

      // R3 / R4: three links compete while outputs are stalled; pointer starts at link 0
      rdy_mode = 1;
      @(negedge clk);
      @(negedge clk);
      rt = mk_route(2, 1, 0, 1, 0, 0, 0);
      base = rx_count;
      fork
         send(0, rt, 4'h1, 16'h1000, 16'h2000);
         send(1, rt, 4'h2, 16'h1001, 16'h2001);
         send(2, rt, 4'h4, 16'h1002, 16'h2002);
         begin
            repeat (12) @(negedge clk);
            #1;
            chk(in_ready, 0, "R4 full queue stalls all links");
            chk(drv_valid[2], 1, "R4 losing link still waiting");
            chk(rx_count, base, "R4 nothing leaves while stalled");
            rdy_mode = 2;
         end
      join
      wait_rx(base + 3, "R4 all parcels drained");
      rdy_mode = 0;
      chk(rx_tid[base],     4'h1, "R3 first grant link0");
      chk(rx_tid[base + 1], 4'h2, "R3 second grant link1");
      chk(rx_tid[base + 2], 4'h4, "R3 third grant link2");
      for (int k = 0; k < 3; k++) begin
         logic [3:0] tg4;
         tg4 = rx_tid[base + k];
         chk({rx_b0[base + k], rx_b1[base + k]},
             {16'h1000 + 16'($clog2(int'(tg4))), 16'h2000 + 16'($clog2(int'(tg4)))}, "R6 beats not interleaved");
      end

      // R3 rotation: after a lone link0 parcel the pointer is at link1, so link2 beats link0
      base = rx_count;
      send(0, rt, 4'h7, 16'h0007, 16'h0008);
      wait_rx(base + 1, "R3 lone parcel");
      fork
         send(0, rt, 4'hC, 16'h000C, 16'h000D);
         send(2, rt, 4'hE, 16'h000E, 16'h000F);
      join
      wait_rx(base + 3, "R3 pair delivered");
      chk(rx_tid[base + 1], 4'hE, "R3 rotation favours link2");
      chk(rx_tid[base + 2], 4'hC, "R3 link0 served next");

      repeat (4) @(negedge clk);
      chk(out_valid, 0, "R10 idle after drain");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule